// File: doc/BRIEF.md
# EEPROM Transaction Sequencer

This block sits between the bit-level serial front end of a 64K x 8 serial EEPROM and its storage. The front end reports start and stop conditions, every received byte, and the master's acknowledge bit after each byte the device sends. From these events the sequencer decides whether to acknowledge a byte. It loads and advances an internal 16-bit address counter. It fetches read data from a behavioural memory read port. It passes accepted write bytes to the page buffer and asks the page-write engine for a write cycle when a stop closes a write.

Reads and writes advance the counter under different wrap rules. A read steps across the whole 64K space and goes from 0xFFFF to 0x0000. A write steps only the low seven bits, so it stays inside its 128-byte page. A random read is made from a dummy write that loads the counter, followed by a repeated start and a read-mode address word. When the protect input is high, write data is still acknowledged but none of it reaches the page buffer. Reads are not affected by the protect input.

The counter has no defined value after reset. A random read is needed to set it before current-address reads can be relied on.

Top module: `eeprom_txn_seq`

## Requirements
- R1: The first byte after a start is an address word. It is accepted only when bits 7:4 are 4'b1010 and bits 2:1 equal `dev_sel`. Bit 3 is ignored, and bit 0 is the direction (1 = read, 0 = write). A rejected word gets no acknowledge, and every later byte and master acknowledge is ignored until the next start.
- R2: After an accepted write-mode word, the next two bytes are the high address byte and then the low address byte. Each is acknowledged. The low byte loads the counter with {high, low}.
- R3: Each further byte of a write is acknowledged. When not protected, it is written to the page buffer at the counter address. The counter then steps its low 7 bits modulo 128 and keeps bits 15:7.
- R4: An accepted read-mode word is acknowledged, and the byte at the counter address is sent. Every byte sent advances the counter by one modulo 65536, so 0xFFFF is followed by 0x0000.
- R5: After a sent byte, a master acknowledge of 0 sends the next byte. A 1 sends nothing more. When no master acknowledge arrives, nothing is sent.
- R6: A write-mode word and two address bytes, followed by a repeated start and a read-mode word, return data from the address just loaded.
- R7: With `wp` high, write data bytes are acknowledged but produce no page buffer write and no write cycle request. The counter still steps, and reads are unaffected.
- R8: A stop that follows at least one unprotected data byte raises `wc_req` for one cycle, with `wc_page` = address bits 15:7 of the data. A stop or repeated start with no such byte raises nothing, and a repeated start drops any pending request.
- R9: Every acknowledge, sent byte, page buffer write and write request appears exactly one clock after the front-end event that causes it. No output pulses during or straight after reset.
- R10: A current-address read after a write starts at the page-wrapped counter value left by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 2 | Hard-wired device select value |
| wp | input | 1 | Write protect, high protects the whole array |
| fe_start | input | 1 | Start or repeated start seen (pulse) |
| fe_stop | input | 1 | Stop seen (pulse) |
| fe_byte_vld | input | 1 | A received byte is on fe_byte (pulse) |
| fe_byte | input | 8 | Received byte |
| fe_mack_vld | input | 1 | Master acknowledge bit sampled (pulse) |
| fe_mack | input | 1 | Master acknowledge value, 0 = continue |
| ack_o | output | 1 | Drive acknowledge for the last byte (pulse) |
| tx_vld | output | 1 | A byte to send is on tx_data (pulse) |
| tx_data | output | 8 | Byte to send |
| mem_raddr | output | 16 | Memory read address (counter value) |
| mem_rdata | input | 8 | Memory read data, same cycle |
| pb_we | output | 1 | Page buffer write strobe |
| pb_addr | output | 16 | Page buffer write address |
| pb_data | output | 8 | Page buffer write data |
| wc_req | output | 1 | Request an internal write cycle (pulse) |
| wc_page | output | 9 | Page to be written |

## Verification
Every result is due exactly one clock after the pulse that causes it, because each output is a single register stage. The memory read is combinational from the counter. The driver pushes the expected acknowledge, byte, buffer write or request into an ordered queue when it issues each stimulus. The monitor samples on the falling edge that follows the capturing rising edge and pops one entry for each output pulse it sees. After each transaction a few idle cycles must leave the queue empty, which catches a missing response. An extra response pops a wrong or absent entry.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DEVW  = 3'd1,
    S_AHI   = 3'd2,
    S_ALO   = 3'd3,
    S_WDAT  = 3'd4,
    S_RWAIT = 3'd5,
    S_REND  = 3'd6
  } seq_state_e;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

endpackage

// File: rtl/eeseq_devmatch.sv
module eeseq_devmatch #(
  parameter int          SEL_W    = 2,
  parameter logic [3:0]  FAMILY   = 4'b1010
) (
  input  logic [3:0]       code_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] pins_i,
  input  logic             rw_i,
  output logic             hit_o,
  output logic             rd_o
);

  function automatic logic f_match(input logic [3:0] code,
                                   input logic [SEL_W-1:0] sel,
                                   input logic [SEL_W-1:0] pins);
    return (code == FAMILY) && (sel == pins);
  endfunction

  assign hit_o = f_match(code_i, sel_i, pins_i);
  assign rd_o  = rw_i;

endmodule

// File: rtl/eeseq_addr_ctr.sv
module eeseq_addr_ctr #(
  parameter int AW = 16,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_rd_i,
  input  logic          step_wr_i,
  output logic [AW-1:0] cnt_o
);

  function automatic logic [AW-1:0] f_rd_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] f_wr_next(input logic [AW-1:0] a);
    logic [PW-1:0] low;
    low = a[PW-1:0] + PW'(1);
    return {a[AW-1:PW], low};
  endfunction

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step_rd_i) begin
      cnt_q <= f_rd_next(cnt_q);
    end else if (step_wr_i) begin
      cnt_q <= f_wr_next(cnt_q);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/eeseq_wr_path.sv
module eeseq_wr_path #(
  parameter int AW = 16,
  parameter int PW = 7,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             wp_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             pb_we_o,
  output logic [AW-1:0]    pb_addr_o,
  output logic [DW-1:0]    pb_data_o,
  output logic             wc_req_o,
  output logic [AW-PW-1:0] wc_page_o,
  output logic             pending_o
);

  logic             take;
  logic             pend_q;
  logic [AW-PW-1:0] page_q;

  assign take      = accept_i && !wp_i;
  assign pending_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_we_o   <= 1'b0;
      pb_addr_o <= '0;
      pb_data_o <= '0;
      wc_req_o  <= 1'b0;
      wc_page_o <= '0;
      pend_q    <= 1'b0;
      page_q    <= '0;
    end else begin
      pb_we_o  <= take;
      wc_req_o <= stop_i && pend_q;
      if (take) begin
        pb_addr_o <= addr_i;
        pb_data_o <= data_i;
        page_q    <= addr_i[AW-1:PW];
      end
      if (stop_i && pend_q) begin
        wc_page_o <= page_q;
      end
      if (start_i || stop_i) begin
        pend_q <= 1'b0;
      end else if (take) begin
        pend_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/eeprom_txn_seq.sv
module eeprom_txn_seq #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         dev_sel,
  input  logic                     wp,
  input  logic                     fe_start,
  input  logic                     fe_stop,
  input  logic                     fe_byte_vld,
  input  logic [DATA_W-1:0]        fe_byte,
  input  logic                     fe_mack_vld,
  input  logic                     fe_mack,
  output logic                     ack_o,
  output logic                     tx_vld,
  output logic [DATA_W-1:0]        tx_data,
  output logic [ADDR_W-1:0]        mem_raddr,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     pb_we,
  output logic [ADDR_W-1:0]        pb_addr,
  output logic [DATA_W-1:0]        pb_data,
  output logic                     wc_req,
  output logic [ADDR_W-PAGE_W-1:0] wc_page
);
  import eeseq_pkg::*;

  localparam int HI_W = ADDR_W - DATA_W;

  seq_state_e st_q, st_d;

  logic              dev_hit, dev_rd;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] cnt_q;

  // named internal events
  logic ev_devw, ev_dev_hit, ev_rd_open, ev_ahi, ev_alo, ev_wdat;
  logic ev_mack0, ev_mack1, ev_rd_issue, rd_waiting, wr_pending;

  eeseq_devmatch #(.SEL_W(SEL_W), .FAMILY(DEV_FAMILY)) u_match (
    .code_i (fe_byte[7:4]),
    .sel_i  (fe_byte[SEL_W:1]),
    .pins_i (dev_sel),
    .rw_i   (fe_byte[0]),
    .hit_o  (dev_hit),
    .rd_o   (dev_rd)
  );

  assign ev_devw     = fe_byte_vld && (st_q == S_DEVW) && !fe_start && !fe_stop;
  assign ev_dev_hit  = ev_devw && dev_hit;
  assign ev_rd_open  = ev_dev_hit && dev_rd;
  assign ev_ahi      = fe_byte_vld && (st_q == S_AHI)  && !fe_start && !fe_stop;
  assign ev_alo      = fe_byte_vld && (st_q == S_ALO)  && !fe_start && !fe_stop;
  assign ev_wdat     = fe_byte_vld && (st_q == S_WDAT) && !fe_start && !fe_stop;
  assign rd_waiting  = (st_q == S_RWAIT);
  assign ev_mack0    = fe_mack_vld && !fe_mack && rd_waiting && !fe_start && !fe_stop;
  assign ev_mack1    = fe_mack_vld &&  fe_mack && rd_waiting && !fe_start && !fe_stop;
  assign ev_rd_issue = ev_rd_open || ev_mack0;

  always_comb begin
    st_d = st_q;
    if (fe_start) begin
      st_d = S_DEVW;
    end else if (fe_stop) begin
      st_d = S_IDLE;
    end else begin
      unique case (st_q)
        S_DEVW: if (fe_byte_vld) st_d = !dev_hit ? S_IDLE : (dev_rd ? S_RWAIT : S_AHI);
        S_AHI:  if (fe_byte_vld) st_d = S_ALO;
        S_ALO:  if (fe_byte_vld) st_d = S_WDAT;
        S_RWAIT: if (ev_mack1) st_d = S_REND;
        default: st_d = st_q;
      endcase
    end
  end

  eeseq_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_alo),
    .load_val_i ({hi_q, fe_byte}),
    .step_rd_i  (ev_rd_issue),
    .step_wr_i  (ev_wdat),
    .cnt_o      (cnt_q)
  );

  eeseq_wr_path #(.AW(ADDR_W), .PW(PAGE_W), .DW(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (ev_wdat),
    .wp_i      (wp),
    .addr_i    (cnt_q),
    .data_i    (fe_byte),
    .start_i   (fe_start),
    .stop_i    (fe_stop),
    .pb_we_o   (pb_we),
    .pb_addr_o (pb_addr),
    .pb_data_o (pb_data),
    .wc_req_o  (wc_req),
    .wc_page_o (wc_page),
    .pending_o (wr_pending)
  );

  assign mem_raddr = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      hi_q    <= '0;
      ack_o   <= 1'b0;
      tx_vld  <= 1'b0;
      tx_data <= '0;
    end else begin
      st_q   <= st_d;
      ack_o  <= ev_dev_hit || ev_ahi || ev_alo || ev_wdat;
      tx_vld <= ev_rd_issue;
      if (ev_ahi)      hi_q    <= fe_byte[HI_W-1:0];
      if (ev_rd_issue) tx_data <= mem_rdata;
    end
  end

endmodule

// File: rtl/eeseq_chk.sv
module eeseq_chk #(
  parameter int AW = 16,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fe_byte_vld,
  input logic          fe_mack_vld,
  input logic          fe_mack,
  input logic          fe_stop,
  input logic          wp,
  input logic          ack_o,
  input logic          tx_vld,
  input logic          pb_we,
  input logic [AW-1:0] pb_addr,
  input logic          wc_req,
  input logic [AW-1:0] cnt_q,
  input logic          rd_waiting,
  input logic          wr_pending
);

  AST_ACK_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(fe_byte_vld)); // R9

  AST_TX_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(fe_byte_vld || fe_mack_vld)); // R4

  AST_NACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_mack_vld && fe_mack && rd_waiting) |=> !tx_vld); // R5

  AST_PB_IS_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |-> ack_o); // R3

  AST_PB_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |-> (cnt_q[AW-1:PW] == pb_addr[AW-1:PW])); // R3

  AST_PB_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we |-> $past(!wp)); // R7

  AST_WC_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wc_req |-> ($past(fe_stop) && $past(wr_pending))); // R8

  AST_NO_BYTE_AND_MACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_vld && pb_we)); // R7

endmodule

bind eeprom_txn_seq eeseq_chk #(.AW(ADDR_W), .PW(PAGE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fe_byte_vld (fe_byte_vld),
  .fe_mack_vld (fe_mack_vld),
  .fe_mack     (fe_mack),
  .fe_stop     (fe_stop),
  .wp          (wp),
  .ack_o       (ack_o),
  .tx_vld      (tx_vld),
  .pb_we       (pb_we),
  .pb_addr     (pb_addr),
  .wc_req      (wc_req),
  .cnt_q       (cnt_q),
  .rd_waiting  (rd_waiting),
  .wr_pending  (wr_pending)
);

// File: tb/eeprom_txn_seq_test.sv
module eeprom_txn_seq_test;

  localparam logic [1:0] SEL = 2'b10;
  localparam logic [7:0] DEVW  = 8'hA4;  // 1010_0_10_0
  localparam logic [7:0] DEVWX = 8'hAC;  // bit 3 set
  localparam logic [7:0] DEVR  = 8'hA5;

  localparam int K_ACK = 1;
  localparam int K_TX  = 2;
  localparam int K_PB  = 3;
  localparam int K_WC  = 4;

  typedef struct {
    int          kind;
    logic [15:0] a;
    logic [7:0]  d;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dev_sel = SEL;
  logic        wp = 1'b0;
  logic        fe_start = 1'b0, fe_stop = 1'b0;
  logic        fe_byte_vld = 1'b0, fe_mack_vld = 1'b0, fe_mack = 1'b0;
  logic [7:0]  fe_byte = '0;
  logic        ack_o, tx_vld, pb_we, wc_req;
  logic [7:0]  tx_data, pb_data, mem_rdata;
  logic [15:0] mem_raddr, pb_addr;
  logic [8:0]  wc_page;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  item_t q[$];
  logic [15:0] mcnt;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return (a[7:0] + a[15:8] * 8'd7) ^ 8'h3C;
  endfunction

  assign mem_rdata = mem_f(mem_raddr);

  eeprom_txn_seq uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .wp(wp),
    .fe_start(fe_start), .fe_stop(fe_stop),
    .fe_byte_vld(fe_byte_vld), .fe_byte(fe_byte),
    .fe_mack_vld(fe_mack_vld), .fe_mack(fe_mack),
    .ack_o(ack_o), .tx_vld(tx_vld), .tx_data(tx_data),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .pb_we(pb_we), .pb_addr(pb_addr), .pb_data(pb_data),
    .wc_req(wc_req), .wc_page(wc_page)
  );

  task automatic push(input int k, input logic [15:0] a, input logic [7:0] d, input string r);
    item_t it;
    it.kind = k; it.a = a; it.d = d; it.req = r;
    q.push_back(it);
  endtask

  task automatic pop_cmp(input int k, input logic [15:0] a, input logic [7:0] d);
    item_t it;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL unexpected output kind=%0d a=%h d=%h, expected none", k, a, d);
    end else begin
      it = q.pop_front();
      if (it.kind != k || it.a != a || it.d != d) begin
        errors++;
        $display("FAIL %s: kind=%0d a=%h d=%h, expected kind=%0d a=%h d=%h",
                 it.req, k, a, d, it.kind, it.a, it.d);
      end
    end
  endtask

  // monitor: outputs are registered, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_o)  pop_cmp(K_ACK, 16'h0, 8'h0);
      if (tx_vld) pop_cmp(K_TX, 16'h0, tx_data);
      if (pb_we)  pop_cmp(K_PB, pb_addr, pb_data);
      if (wc_req) pop_cmp(K_WC, {7'h0, wc_page}, 8'h0);
    end
  end

  task automatic drain(input string r);
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d responses missing, expected 0", r, q.size());
    end
    q.delete();
  endtask

  task automatic p_start;
    @(negedge clk); fe_start = 1'b1;
    @(negedge clk); fe_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic p_stop;
    @(negedge clk); fe_stop = 1'b1;
    @(negedge clk); fe_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic p_byte(input logic [7:0] b);
    @(negedge clk); fe_byte = b; fe_byte_vld = 1'b1;
    @(negedge clk); fe_byte_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic p_mack(input logic v);
    @(negedge clk); fe_mack = v; fe_mack_vld = 1'b1;
    @(negedge clk); fe_mack_vld = 1'b0;
    @(negedge clk);
  endtask

  // dummy write: R2
  task automatic set_addr(input logic [15:0] a);
    p_start;
    push(K_ACK, 0, 0, "R1"); p_byte(DEVW);
    push(K_ACK, 0, 0, "R2"); p_byte(a[15:8]);
    push(K_ACK, 0, 0, "R2"); p_byte(a[7:0]);
    mcnt = a;
  endtask

  task automatic wr_data(input logic [7:0] d, input string r);
    push(K_ACK, 0, 0, r);
    if (!wp) push(K_PB, mcnt, d, r);
    mcnt = {mcnt[15:7], mcnt[6:0] + 7'd1};
    p_byte(d);
  endtask

  task automatic rd_open(input string r);
    p_start;
    push(K_ACK, 0, 0, r);
    push(K_TX, 0, mem_f(mcnt), r);
    mcnt = mcnt + 16'd1;
    p_byte(DEVR);
  endtask

  task automatic rd_more(input string r);
    push(K_TX, 0, mem_f(mcnt), r);
    mcnt = mcnt + 16'd1;
    p_mack(1'b0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    checks++;
    if (ack_o || tx_vld || pb_we || wc_req) begin
      errors++;
      $display("FAIL R9 reset: pulses %b%b%b%b, expected 0000", ack_o, tx_vld, pb_we, wc_req);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // byte with no start is ignored
    p_byte(DEVW);
    drain("R1 no start");

    // R1: wrong family, later bytes ignored
    p_start; p_byte(8'hB4); p_byte(8'h12); p_byte(8'h34); p_stop;
    drain("R1 family");
    // R1: wrong select pins
    p_start; p_byte(8'hA2); p_mack(1'b0); p_stop;
    drain("R1 pins");
    // R1: bit 3 is ignored
    p_start; push(K_ACK, 0, 0, "R1 bit3"); p_byte(DEVWX); p_stop;
    drain("R1 bit3");

    // R6/R2: random read at 0x1234, then sequential, then nack
    set_addr(16'h1234);
    rd_open("R6");          // repeated start without data: no wc (R8)
    rd_more("R5 mack0");
    p_mack(1'b1);           // R5: nothing more
    p_mack(1'b0);           // ignored after a nack
    p_stop;
    drain("R6 random read");

    // R4: wrap across the top of the array
    set_addr(16'hFFFE);
    rd_open("R4");
    rd_more("R4");
    rd_more("R4 wrap");
    p_mack(1'b1); p_stop;
    drain("R4 wrap");
    // R4: current-address read continues after wrap; R5 no master ack
    rd_open("R4 current");
    repeat (6) @(negedge clk);
    p_stop;
    drain("R5 no mack");

    // R3/R8: page wrapped write
    set_addr(16'h037E);
    wr_data(8'h11, "R3");
    wr_data(8'h22, "R3");
    wr_data(8'h33, "R3 page wrap");
    push(K_WC, 16'h0006, 0, "R8");
    p_stop;
    drain("R3 write");
    // R10: current read after write
    rd_open("R10");
    p_mack(1'b1); p_stop;
    drain("R10");

    // R7: protected write
    wp = 1'b1;
    set_addr(16'h2000);
    wr_data(8'hAA, "R7");
    wr_data(8'hBB, "R7");
    p_stop;
    drain("R7 no request");
    rd_open("R7 read while protected");
    rd_more("R7 read while protected");
    p_mack(1'b1); p_stop;
    drain("R7 read");
    wp = 1'b0;

    // R8: repeated start after data drops the request
    set_addr(16'h4100);
    wr_data(8'h5A, "R8");
    rd_open("R8 rep start");
    p_mack(1'b1); p_stop;
    drain("R8 rep start");
    // R8: address only, then stop
    set_addr(16'h0800);
    p_stop;
    drain("R8 address only");

    done = 1;
    finish_run;
  end

endmodule